// File: doc/BRIEF.md
# I2C Register-Bank Target

This block lets an I2C bus master read and write a bank of 8-bit control registers. SCL and SDA are brought into the system clock domain through two-flop synchronizers. START, repeated START and STOP are found by watching SDA move while SCL is high. The block answers to a 7-bit device address. The upper five bits of that address are fixed at `11000` and the lower two come from strap inputs. SDA is driven open drain: the `sda_oe_o` output pulls the line low when it is high and releases it otherwise.

A write transaction carries the device address with R/W = 0. The first byte after it loads the register pointer, and every later byte goes into the register at the pointer, which then advances. The burst has no length limit and ends only on STOP.

A read transaction is done in two steps. The master first writes the pointer, then issues a repeated START and the address with R/W = 1. The block returns the register at the pointer and keeps returning the next one for as long as the master ACKs. The register contents are visible to the rest of the chip on a flat output bus.

Top module: `i2c_regbank_target`

## Requirements
- R1: The block ACKs an address byte by driving SDA low during the ninth SCL pulse only when the byte's upper seven bits, MSB first, equal `1,1,0,0,0,strap[1],strap[0]`. Bit 0 of that byte is R/W, with 1 meaning read. Any other address gets no ACK.
- R2: After an address that does not match, SDA stays released and every following byte is ignored until the next START, so no register changes.
- R3: In a write, the first byte after the address ACK loads the pointer (its low log2(NUM_REGS) bits) and is ACKed. Each later byte, MSB first, is stored in the register at the pointer and ACKed.
- R4: The pointer advances by one after each data byte written or sent, and wraps from NUM_REGS-1 to 0.
- R5: A write burst of any length ends only at STOP. STOP returns the block to idle with SDA released and keeps the pointer value for the next transaction.
- R6: After a read address is ACKed, the block sends the register at the pointer MSB first. A master ACK brings the next register; a master NACK leaves SDA released.
- R7: A START or STOP that arrives in the middle of a byte discards the partial byte, and no register is written.
- R8: The SDA drive changes only while the synchronized SCL is low, and so stays constant for the whole of each SCL high phase.
- R9: After reset, all registers hold 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| strap_i | input | 2 | Low two device-address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_bank_o | output | NUM_REGS*8 | All registers; register k is bits [8k+7:8k] |

## Verification
Every reaction of the block follows an SCL or SDA pad edge by three system clocks: two synchronizer stages and then the state register. The ACK and read-data drive therefore appears three clocks after SCL falls, and a register write becomes visible three clocks after the falling edge that closes the eighth bit. The bench spaces its SCL phases six clocks apart. It samples SDA three clocks into each high phase and looks at the register bus only after STOP, so every sample falls well after the due cycle and before the next pad edge. The SDA drive is recorded at the start and at the end of each high phase, which checks that it held steady.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    // Byte-level phases of the target
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WR_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

    // Fixed upper part of the device address
    localparam logic [4:0] DEV_FIXED = 5'b11000;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // stages [0..SYNC_STAGES-1] synchronize, the last one holds the prior value
    logic [SYNC_STAGES:0] scl_pipe_q, sda_pipe_q;
    logic scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[SYNC_STAGES-1:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_s    = scl_pipe_q[SYNC_STAGES-1];
    assign sda_s    = sda_pipe_q[SYNC_STAGES-1];
    assign scl_prev = scl_pipe_q[SYNC_STAGES];
    assign sda_prev = sda_pipe_q[SYNC_STAGES];

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store #(
    parameter int NUM_REGS = 16,
    localparam int PTR_W = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] bank_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= 8'h00;
            else if (wr_en && wr_addr == PTR_W'(g))
                val_q <= wr_data;
        end
        assign bank_o[g*8 +: 8] = val_q;
    end

    assign rd_data = bank_o[rd_addr*8 +: 8];

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [1:0]            strap_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] reg_bank_o
);
    localparam int PTR_W = $clog2(NUM_REGS);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_REGS - 1);

    typedef struct packed {
        tgt_state_e       st;
        logic [3:0]       bits;
        logic [7:0]       sh;
        logic [PTR_W-1:0] ptr;
        logic             rw;
        logic             oe;
        logic             mack;
    } tgt_regs_t;

    tgt_regs_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;
    logic [PTR_W-1:0] ptr_inc;
    logic             addr_hit;

    // observation points for the bound checker
    tgt_state_e       cur_st;
    logic [PTR_W-1:0] ptr_cur;

    i2c_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_reg_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (q.ptr),
        .rd_data (rd_data),
        .bank_o  (reg_bank_o)
    );

    assign ptr_inc  = (q.ptr == PTR_LAST) ? '0 : q.ptr + 1'b1;
    assign addr_hit = (q.sh[7:1] == {DEV_FIXED, strap_i});

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = q.ptr;
        wr_data = q.sh;
        if (start_det) begin
            d.st   = ST_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (stop_det) begin
            d.st   = ST_IDLE;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (scl_rise) begin
            unique case (q.st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    d.sh   = {q.sh[6:0], sda_s};
                    d.bits = q.bits + 4'd1;
                end
                ST_RDATA: d.bits = q.bits + 4'd1;
                ST_RACK:  d.mack = ~sda_s;
                default: ;
            endcase
        end else if (scl_fall) begin
            unique case (q.st)
                ST_ADDR: if (q.bits == 4'd8) begin
                    if (addr_hit) begin
                        d.oe = 1'b1;
                        d.rw = q.sh[0];
                        d.st = ST_ADDR_ACK;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                ST_ADDR_ACK: begin
                    d.bits = '0;
                    if (q.rw) begin
                        d.st = ST_RDATA;
                        d.sh = rd_data;
                        d.oe = ~rd_data[7];
                    end else begin
                        d.st = ST_PTR;
                        d.oe = 1'b0;
                    end
                end
                ST_PTR: if (q.bits == 4'd8) begin
                    d.ptr = q.sh[PTR_W-1:0];
                    d.oe  = 1'b1;
                    d.st  = ST_PTR_ACK;
                end
                ST_WDATA: if (q.bits == 4'd8) begin
                    wr_en = 1'b1;
                    d.ptr = ptr_inc;
                    d.oe  = 1'b1;
                    d.st  = ST_WR_ACK;
                end
                ST_PTR_ACK, ST_WR_ACK: begin
                    d.oe   = 1'b0;
                    d.bits = '0;
                    d.st   = ST_WDATA;
                end
                ST_RDATA: begin
                    if (q.bits == 4'd8) begin
                        d.oe  = 1'b0;
                        d.ptr = ptr_inc;
                        d.st  = ST_RACK;
                    end else begin
                        d.sh = {q.sh[6:0], 1'b0};
                        d.oe = ~q.sh[6];
                    end
                end
                ST_RACK: begin
                    if (q.mack) begin
                        d.st   = ST_RDATA;
                        d.bits = '0;
                        d.sh   = rd_data;
                        d.oe   = ~rd_data[7];
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, bits: '0, sh: '0, ptr: '0, rw: 1'b0, oe: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign cur_st   = q.st;
    assign ptr_cur  = q.ptr;

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int PTR_W = $clog2(NUM_REGS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  sda_oe,
    input tgt_state_e            cur_st,
    input logic [PTR_W-1:0]      ptr_cur,
    input logic                  wr_en,
    input logic [PTR_W-1:0]      wr_addr,
    input logic [7:0]            wr_data,
    input logic [NUM_REGS*8-1:0] reg_bank
);
    logic [PTR_W-1:0] ptr_expect;
    always_comb begin
        if (ptr_cur == PTR_W'(NUM_REGS - 1))
            ptr_expect = '0;
        else
            ptr_expect = ptr_cur + 1'b1;
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_IDLE) |-> !sda_oe); // R2
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (cur_st == ST_IDLE && !sda_oe)); // R5
    AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (cur_st == ST_ADDR && !wr_en)); // R7
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reg_bank[$past(wr_addr)*8 +: 8] == $past(wr_data))); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr_cur == $past(ptr_expect))); // R4

endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .cur_st    (cur_st),
    .ptr_cur   (ptr_cur),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .reg_bank  (reg_bank_o)
);

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;
    localparam int NR = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] strap = 2'b00;
    logic sda_oe;
    logic [NR*8-1:0] bank;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int r8_viol = 0;
    logic [7:0] model [NR];

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;   // 50 MHz

    i2c_regbank_target #(.NUM_REGS(NR)) i_i2c_regbank_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_oe_o   (sda_oe),
        .reg_bank_o (bank)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one SCL pulse; SCL is low on entry and exit
    task automatic bit_cycle(input logic b, output logic seen);
        logic oe_at_rise;
        wait_clk(3);
        m_sda = b;
        wait_clk(3);
        scl = 1'b1;
        oe_at_rise = sda_oe;
        wait_clk(3);
        seen = sda_line;
        wait_clk(3);
        if (sda_oe != oe_at_rise) r8_viol++;
        scl = 1'b0;
    endtask

    task automatic do_start();
        if (scl) begin
            m_sda = 1'b0;
            wait_clk(6);
            scl = 1'b0;
        end else begin
            wait_clk(3);
            m_sda = 1'b1;
            wait_clk(3);
            scl = 1'b1;
            wait_clk(6);
            m_sda = 1'b0;
            wait_clk(6);
            scl = 1'b0;
        end
    endtask

    task automatic do_stop();
        wait_clk(3);
        m_sda = 1'b0;
        wait_clk(3);
        scl = 1'b1;
        wait_clk(6);
        m_sda = 1'b1;
        wait_clk(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            v[i] = s;
        end
        bit_cycle(~give_ack, s);
    endtask

    function automatic logic [7:0] dev_byte(input logic rd);
        return {5'b11000, strap, rd};
    endfunction

    // write burst starting at ptr, checks every ACK
    task automatic write_burst(input int ptr, input int cnt, input int seed);
        logic a;
        int p;
        logic [7:0] v;
        do_start();
        send_byte(dev_byte(1'b0), a);
        check("R1 write address ACK", a, 1);
        send_byte(8'(ptr), a);
        check("R3 pointer byte ACK", a, 1);
        p = ptr;
        for (int k = 0; k < cnt; k++) begin
            v = 8'((seed + k * 37) & 255);
            send_byte(v, a);
            check("R3 data byte ACK", a, 1);
            model[p] = v;
            p = (p + 1) % NR;
        end
        do_stop();
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < NR; k++)
            check(req, int'(bank[k*8 +: 8]), int'(model[k]));
    endtask

    // read burst of cnt registers; set_ptr < 0 keeps the current pointer
    task automatic read_burst(input int set_ptr, input int first, input int cnt, input string req);
        logic a;
        logic [7:0] v;
        int p;
        if (set_ptr >= 0) begin
            do_start();
            send_byte(dev_byte(1'b0), a);
            check("R1 address ACK before read", a, 1);
            send_byte(8'(set_ptr), a);
            check("R3 pointer ACK before read", a, 1);
        end
        do_start();
        send_byte(dev_byte(1'b1), a);
        check("R1 read address ACK", a, 1);
        p = first;
        for (int k = 0; k < cnt; k++) begin
            recv_byte(k != cnt - 1, v);
            check(req, int'(v), int'(model[p]));
            p = (p + 1) % NR;
        end
        check("R6 SDA released after NACK", int'(sda_oe), 0);
        do_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic a;
        logic s;
        for (int k = 0; k < NR; k++) model[k] = 8'h00;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R9 reset state
        check("R9 SDA released after reset", int'(sda_oe), 0);
        check_bank("R9 register reset value");

        // R3/R4 three-byte write starting at 0
        do_start();
        send_byte(dev_byte(1'b0), a);
        check("R1 ACK straps 00", a, 1);
        send_byte(8'h00, a);
        send_byte(8'h0E, a);
        send_byte(8'hD8, a);
        send_byte(8'hE1, a);
        check("R3 last data ACK", a, 1);
        do_stop();
        model[0] = 8'h0E; model[1] = 8'hD8; model[2] = 8'hE1;
        check_bank("R4 successive registers filled");

        // R4/R5 long burst across the wrap
        write_burst(14, 20, 9);
        check_bank("R5 long burst wraps to register 0");

        // R6 read bursts, including a wrap
        read_burst(0, 0, 3, "R6 read from pointer 0");
        read_burst(14, 14, 5, "R4 read wraps past last register");

        // R5 pointer kept across STOP: write one byte at 5, then read
        write_burst(5, 1, 200);
        read_burst(-1, 6, 2, "R5 pointer retained after STOP");

        // full sweep: write all registers then read them back in one burst
        write_burst(0, NR, 71);
        check_bank("R3 full sweep write");
        read_burst(0, 0, NR, "R6 full sweep read");

        // R2 non-matching address ignored
        do_start();
        send_byte({5'b11000, ~strap, 1'b0}, a);
        check("R2 no ACK on wrong strap bits", a, 0);
        send_byte(8'h02, a);
        check("R2 pointer byte ignored", a, 0);
        send_byte(8'hAA, a);
        check("R2 data byte ignored", a, 0);
        do_stop();
        check_bank("R2 registers unchanged");

        // R7 partial byte aborted by STOP
        do_start();
        send_byte(dev_byte(1'b0), a);
        send_byte(8'h03, a);
        for (int k = 0; k < 4; k++) bit_cycle(k[0], s);
        do_stop();
        check_bank("R7 partial byte not written after STOP");

        // R7 partial byte aborted by repeated START, then a normal write
        do_start();
        send_byte(dev_byte(1'b0), a);
        send_byte(8'h04, a);
        for (int k = 0; k < 5; k++) bit_cycle(1'b1, s);
        do_start();
        send_byte(dev_byte(1'b0), a);
        check("R7 address ACK after repeated START", a, 1);
        send_byte(8'h08, a);
        send_byte(8'h5A, a);
        do_stop();
        model[8] = 8'h5A;
        check_bank("R7 only completed byte written");

        // R1 address sweep over all straps and all 7-bit addresses
        for (int st = 0; st < 4; st++) begin
            strap = 2'(st);
            for (int ad = 0; ad < 128; ad++) begin
                do_start();
                send_byte({7'(ad), 1'b0}, a);
                do_stop();
                check("R1 address match sweep", int'(a), int'(ad == (96 + st)));
            end
        end
        check_bank("R2 sweep leaves registers unchanged");

        check("R8 SDA drive steady while SCL high", r8_viol, 0);

        summary();
        $finish;
    end

endmodule